// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits in front of one multiprocessor and decides, cycle by cycle, whether an incoming thread block may become resident. Each request names how many threads the block has and how many registers each thread needs. The controller multiplies the two into the block's register demand. It then checks three pools together: free block slots, free thread capacity and free register-file entries. Only a block that fits whole in all three is accepted. A block is never split or partly admitted.

On acceptance the controller takes the three amounts out of its occupancy counters. It records them against the lowest free slot and returns that slot number to the requester. When the block later retires, the requester presents the slot number on the release port. The controller then returns exactly the recorded amounts, whatever the request inputs carry at that moment. Registers held by a resident block stay unavailable to every other block until that release. A request with an impossible thread count is refused with an error flag instead of being held waiting.

The default capacity is 8 resident blocks, 768 resident threads and 8192 register entries, with 1 to 512 threads per block.

Top module: `admit_ctrl`

## Requirements
- R1: After reset the free counters read 8 blocks, 768 threads and 8192 register entries, and `req_ready` is low while `req_valid` is low.
- R2: A block's register demand is `req_threads` × `req_regs`. `req_ready` is high only when `req_valid` is high, the thread count is legal, `req_threads` ≤ `free_threads`, the demand ≤ `free_regs`, and at least one slot is free. When `req_ready` is low, the request stalls and changes nothing.
- R3: A grant (`req_valid` and `req_ready` high at a rising edge) lowers `free_blocks` by 1, `free_threads` by `req_threads` and `free_regs` by the demand, all visible after that edge.
- R4: `grant_slot` gives the lowest-numbered slot that holds no resident block, and the granted block occupies that slot.
- R5: A release (`rel_valid` high, `rel_slot` naming an occupied slot) frees that slot. It adds back exactly the thread count and register demand recorded at grant time, plus one block, independent of the request inputs.
- R6: A release naming a slot that holds no block is ignored: all three free counters stay unchanged.
- R7: A grant and a release in the same cycle are both applied, so each counter moves by the granted amount taken and the released amount returned. The fit check uses only the counters as they stood before that edge.
- R8: A request with `req_threads` equal to 0 or above 512 raises `req_error` and keeps `req_ready` low, leaving every counter unchanged. A legal request never raises `req_error`.
- R9: Starting empty, a run of identical requests with T threads and R registers per thread admits exactly min(8, ⌊768/T⌋, ⌊8192/(R·T)⌋) blocks, the last term being dropped when R·T is 0. `free_blocks` always equals 8 minus the number of occupied slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A block is offered for admission |
| req_threads | input | 10 | Thread count of the offered block |
| req_regs | input | 8 | Registers needed per thread |
| req_ready | output | 1 | Offer accepted this cycle (all three pools fit) |
| req_error | output | 1 | Offer refused: thread count 0 or above the per-block limit |
| grant_slot | output | 3 | Slot number assigned when accepted |
| rel_valid | input | 1 | A resident block retires |
| rel_slot | input | 3 | Slot number of the retiring block |
| free_blocks | output | 4 | Unoccupied block slots |
| free_threads | output | 10 | Unreserved thread capacity |
| free_regs | output | 14 | Unreserved register-file entries |

## Verification
The main check is a sweep that fills an empty controller with identical blocks over a grid of thread counts and register-per-thread values. It compares the number admitted against the arithmetic minimum of the three pool limits. Small thread counts with few registers hit the slot limit, large thread counts hit the thread limit, and heavy register use hits the register limit, so the sweep shows which of the three checks stops admission, including the two- and three-block cases near 2560 and 2816 entries. Directed patterns add illegal thread counts at 0 and 513 against a legal 512, a release of an empty slot, and a grant and release in the same cycle. A release made while the request inputs carry unrelated values shows that the restored amounts come from the grant record.

// File: rtl/admit_pkg.sv
package admit_pkg;

    localparam int DEF_SLOTS       = 8;
    localparam int DEF_THREADS     = 768;
    localparam int DEF_REGS        = 8192;
    localparam int DEF_BLK_THREADS = 512;
    localparam int DEF_RPT_W       = 8;

    typedef enum logic [1:0] {
        V_IDLE = 2'd0,
        V_BAD  = 2'd1,
        V_WAIT = 2'd2,
        V_GO   = 2'd3
    } verdict_e;

    function automatic int cnt_w(input int n);
        return (n > 1) ? $clog2(n + 1) : 1;
    endfunction

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic verdict_e judge(input logic valid, input logic legal,
                                       input logic fit_all);
        if (!valid)       return V_IDLE;
        else if (!legal)  return V_BAD;
        else if (!fit_all) return V_WAIT;
        else              return V_GO;
    endfunction

endpackage

// File: rtl/admit_demand.sv
module admit_demand #(
    parameter int TW      = 10,
    parameter int RPW     = 8,
    parameter int BLK_MAX = 512
) (
    input  logic [TW-1:0]     threads,
    input  logic [RPW-1:0]    rpt,
    output logic [TW+RPW-1:0] demand,
    output logic              legal
);
    localparam int DW = TW + RPW;
    localparam logic [TW-1:0] BLK_MAX_V = TW'(BLK_MAX);

    always_comb begin
        demand = DW'(threads) * DW'(rpt);
        legal  = (threads != '0) && (threads <= BLK_MAX_V);
    end
endmodule

// File: rtl/admit_pool.sv
module admit_pool #(
    parameter int CAP = 768,
    parameter int FW  = 10,
    parameter int DW  = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] need,
    input  logic          take,
    input  logic          give,
    input  logic [FW-1:0] give_amt,
    output logic [FW-1:0] free_o,
    output logic          fits
);
    localparam int CW = (DW > FW) ? DW : FW;

    logic [FW-1:0] free_q;
    logic [FW-1:0] take_amt;
    logic [FW-1:0] back_amt;

    always_comb begin
        fits     = CW'(need) <= CW'(free_q);
        take_amt = take ? FW'(need) : '0;
        back_amt = give ? give_amt : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) free_q <= FW'(CAP);
        else     free_q <= free_q - take_amt + back_amt;
    end

    assign free_o = free_q;
endmodule

// File: rtl/admit_slots.sv
module admit_slots #(
    parameter int SLOTS = 8,
    parameter int SW    = 3,
    parameter int TW    = 10,
    parameter int RW    = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic [TW-1:0]    alloc_thr,
    input  logic [RW-1:0]    alloc_reg,
    input  logic             rel_valid,
    input  logic [SW-1:0]    rel_slot,
    output logic             rel_hit,
    output logic [TW-1:0]    rel_thr,
    output logic [RW-1:0]    rel_reg,
    output logic             any_free,
    output logic [SW-1:0]    first_free,
    output logic [SLOTS-1:0] occ
);
    logic [SLOTS-1:0] occ_q;
    logic [TW-1:0]    thr_q [SLOTS];
    logic [RW-1:0]    reg_q [SLOTS];

    always_comb begin
        first_free = '0;
        any_free   = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!occ_q[i]) begin
                first_free = SW'(i);
                any_free   = 1'b1;
            end
        end
    end

    always_comb begin
        rel_hit = rel_valid && occ_q[rel_slot];
        rel_thr = thr_q[rel_slot];
        rel_reg = reg_q[rel_slot];
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic          occ_r;
        logic [TW-1:0] thr_r;
        logic [RW-1:0] reg_r;
        logic          hit_alloc;
        logic          hit_rel;

        assign hit_alloc = alloc && (first_free == SW'(s));
        assign hit_rel   = rel_hit && (rel_slot == SW'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                occ_r <= 1'b0;
                thr_r <= '0;
                reg_r <= '0;
            end else if (hit_alloc) begin
                occ_r <= 1'b1;
                thr_r <= alloc_thr;
                reg_r <= alloc_reg;
            end else if (hit_rel) begin
                occ_r <= 1'b0;
            end
        end

        assign occ_q[s] = occ_r;
        assign thr_q[s] = thr_r;
        assign reg_q[s] = reg_r;
    end

    assign occ = occ_q;
endmodule

// File: rtl/admit_ctrl.sv
module admit_ctrl
    import admit_pkg::*;
#(
    parameter int SLOTS           = DEF_SLOTS,
    parameter int MAX_THREADS     = DEF_THREADS,
    parameter int REG_ENTRIES     = DEF_REGS,
    parameter int MAX_BLK_THREADS = DEF_BLK_THREADS,
    parameter int RPW             = DEF_RPT_W,
    parameter int TW              = cnt_w(MAX_BLK_THREADS),
    parameter int SW              = idx_w(SLOTS),
    parameter int FBW             = cnt_w(SLOTS),
    parameter int FTW             = cnt_w(MAX_THREADS),
    parameter int FRW             = cnt_w(REG_ENTRIES)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic [TW-1:0]  req_threads,
    input  logic [RPW-1:0] req_regs,
    output logic           req_ready,
    output logic           req_error,
    output logic [SW-1:0]  grant_slot,
    input  logic           rel_valid,
    input  logic [SW-1:0]  rel_slot,
    output logic [FBW-1:0] free_blocks,
    output logic [FTW-1:0] free_threads,
    output logic [FRW-1:0] free_regs
);
    localparam int DMW = TW + RPW;

    logic [DMW-1:0]   demand;
    logic             legal;
    logic             fit_blk, fit_thr, fit_reg;
    logic             grant;
    verdict_e         verdict;
    logic             rel_hit;
    logic [TW-1:0]    rel_thr;
    logic [FRW-1:0]   rel_reg;
    logic             any_free;
    logic [SW-1:0]    first_free;
    logic [SLOTS-1:0] occ;

    admit_demand #(.TW(TW), .RPW(RPW), .BLK_MAX(MAX_BLK_THREADS)) u_demand (
        .threads (req_threads),
        .rpt     (req_regs),
        .demand  (demand),
        .legal   (legal)
    );

    always_comb begin
        verdict   = judge(req_valid, legal, fit_blk && fit_thr && fit_reg);
        req_ready = (verdict == V_GO);
        req_error = (verdict == V_BAD);
        grant     = req_ready;
    end

    admit_pool #(.CAP(SLOTS), .FW(FBW), .DW(1)) u_blk_pool (
        .clk      (clk),
        .rst      (rst),
        .need     (1'b1),
        .take     (grant),
        .give     (rel_hit),
        .give_amt (FBW'(1)),
        .free_o   (free_blocks),
        .fits     (fit_blk)
    );

    admit_pool #(.CAP(MAX_THREADS), .FW(FTW), .DW(TW)) u_thr_pool (
        .clk      (clk),
        .rst      (rst),
        .need     (req_threads),
        .take     (grant),
        .give     (rel_hit),
        .give_amt (FTW'(rel_thr)),
        .free_o   (free_threads),
        .fits     (fit_thr)
    );

    admit_pool #(.CAP(REG_ENTRIES), .FW(FRW), .DW(DMW)) u_reg_pool (
        .clk      (clk),
        .rst      (rst),
        .need     (demand),
        .take     (grant),
        .give     (rel_hit),
        .give_amt (rel_reg),
        .free_o   (free_regs),
        .fits     (fit_reg)
    );

    admit_slots #(.SLOTS(SLOTS), .SW(SW), .TW(TW), .RW(FRW)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .alloc      (grant),
        .alloc_thr  (req_threads),
        .alloc_reg  (FRW'(demand)),
        .rel_valid  (rel_valid),
        .rel_slot   (rel_slot),
        .rel_hit    (rel_hit),
        .rel_thr    (rel_thr),
        .rel_reg    (rel_reg),
        .any_free   (any_free),
        .first_free (first_free),
        .occ        (occ)
    );

    assign grant_slot = first_free;
endmodule

// File: rtl/admit_ctrl_chk.sv
module admit_ctrl_chk #(
    parameter int SLOTS = 8,
    parameter int TW    = 10,
    parameter int RPW   = 8,
    parameter int SW    = 3,
    parameter int FBW   = 4,
    parameter int FTW   = 10,
    parameter int FRW   = 14
) (
    input logic           clk,
    input logic           rst,
    input logic           req_valid,
    input logic [TW-1:0]  req_threads,
    input logic [RPW-1:0] req_regs,
    input logic           req_ready,
    input logic           req_error,
    input logic [SW-1:0]  grant_slot,
    input logic           rel_valid,
    input logic [SW-1:0]  rel_slot,
    input logic [FBW-1:0] free_blocks,
    input logic [FTW-1:0] free_threads,
    input logic [FRW-1:0] free_regs,
    input logic [SLOTS-1:0] occ,
    input logic           rel_hit
);
    // R2: an accepted offer fits every pool
    a_r2_ready_fits: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (req_valid && int'(req_threads) <= int'(free_threads)
                       && int'(req_threads) * int'(req_regs) <= int'(free_regs)
                       && free_blocks != '0));

    // R3: a grant without a return lowers the thread pool by the count
    a_r3_thread_take: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !rel_hit) |=>
        int'(free_threads) == $past(int'(free_threads)) - $past(int'(req_threads)));

    // R4: the offered slot is empty
    a_r4_slot_empty: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !occ[grant_slot]);

    // R6: releasing an empty slot with no grant leaves counters alone
    a_r6_ignore_empty: assert property (@(posedge clk) disable iff (rst)
        (rel_valid && !occ[rel_slot] && !req_ready) |=>
        ($stable(free_threads) && $stable(free_regs) && $stable(free_blocks)));

    // R8: an illegal count is never accepted
    a_r8_bad_refused: assert property (@(posedge clk) disable iff (rst)
        req_error |-> !req_ready);

    // R9: slot counter agrees with the occupancy map
    a_r9_slot_count: assert property (@(posedge clk) disable iff (rst)
        int'(free_blocks) == SLOTS - $countones(occ));
endmodule

bind admit_ctrl admit_ctrl_chk #(
    .SLOTS(SLOTS), .TW(TW), .RPW(RPW), .SW(SW),
    .FBW(FBW), .FTW(FTW), .FRW(FRW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_threads  (req_threads),
    .req_regs     (req_regs),
    .req_ready    (req_ready),
    .req_error    (req_error),
    .grant_slot   (grant_slot),
    .rel_valid    (rel_valid),
    .rel_slot     (rel_slot),
    .free_blocks  (free_blocks),
    .free_threads (free_threads),
    .free_regs    (free_regs),
    .occ          (occ),
    .rel_hit      (rel_hit)
);

// File: tb/admit_ctrl_tb.sv
module admit_ctrl_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [9:0] req_threads = '0;
    logic [7:0] req_regs = '0;
    logic       req_ready, req_error;
    logic [2:0] grant_slot;
    logic       rel_valid = 1'b0;
    logic [2:0] rel_slot = '0;
    logic [3:0] free_blocks;
    logic [9:0] free_threads;
    logic [13:0] free_regs;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    admit_ctrl u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_threads(req_threads), .req_regs(req_regs),
        .req_ready(req_ready), .req_error(req_error), .grant_slot(grant_slot),
        .rel_valid(rel_valid), .rel_slot(rel_slot),
        .free_blocks(free_blocks), .free_threads(free_threads), .free_regs(free_regs)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int fit_count(input int t, input int r);
        int n = 8;
        if (768 / t < n) n = 768 / t;
        if (r * t > 0 && 8192 / (r * t) < n) n = 8192 / (r * t);
        return n;
    endfunction

    // look at the combinational answer, then withdraw before the edge
    task automatic probe(input int t, input int r, output int rdy, output int err);
        req_threads = 10'(t); req_regs = 8'(r); req_valid = 1'b1;
        #1 rdy = int'(req_ready); err = int'(req_error);
        #1 req_valid = 1'b0;
        @(negedge clk);
    endtask

    // offer across one edge; state after it is visible on return
    task automatic offer(input int t, input int r, output int rdy, output int slot);
        req_threads = 10'(t); req_regs = 8'(r); req_valid = 1'b1;
        #1 rdy = int'(req_ready); slot = int'(grant_slot);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic retire(input int s);
        rel_slot = 3'(s); rel_valid = 1'b1;
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int rdy, err, slot, cnt, exp;
        int tlist [9] = '{1, 32, 64, 96, 128, 192, 256, 384, 512};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 free_blocks", int'(free_blocks), 8);
        chk("R1 free_threads", int'(free_threads), 768);
        chk("R1 free_regs", int'(free_regs), 8192);
        chk("R1 ready idle", int'(req_ready), 0);

        // R8 illegal counts versus the legal maximum
        probe(0, 1, rdy, err);
        chk("R8 zero err", err, 1); chk("R8 zero ready", rdy, 0);
        probe(513, 1, rdy, err);
        chk("R8 513 err", err, 1); chk("R8 513 ready", rdy, 0);
        probe(512, 1, rdy, err);
        chk("R8 512 err", err, 0); chk("R8 512 ready", rdy, 1);
        chk("R8 unchanged threads", int'(free_threads), 768);
        chk("R8 unchanged regs", int'(free_regs), 8192);

        // R7 grant and release together
        offer(256, 10, rdy, slot);
        chk("R4 first slot", slot, 0);
        offer(256, 10, rdy, slot);
        chk("R4 second slot", slot, 1);
        chk("R3 threads", int'(free_threads), 256);
        chk("R3 regs", int'(free_regs), 3072);
        rel_slot = 3'd0; rel_valid = 1'b1;
        offer(128, 5, rdy, slot);
        rel_valid = 1'b0;
        chk("R7 ready", rdy, 1);
        chk("R7 slot", slot, 2);
        chk("R7 threads", int'(free_threads), 384);
        chk("R7 regs", int'(free_regs), 4992);
        chk("R7 blocks", int'(free_blocks), 6);

        // R6 release of an empty slot (slot 5)
        retire(5);
        chk("R6 threads", int'(free_threads), 384);
        chk("R6 regs", int'(free_regs), 4992);
        chk("R6 blocks", int'(free_blocks), 6);

        // R5 restore comes from the record, not the request inputs
        req_threads = 10'd1; req_regs = 8'd200;
        retire(2);
        chk("R5 threads", int'(free_threads), 512);
        chk("R5 regs", int'(free_regs), 5632);
        chk("R5 blocks", int'(free_blocks), 7);
        retire(1);
        chk("R5 empty regs", int'(free_regs), 8192);

        // R9 sweep from empty
        foreach (tlist[i]) begin
            for (int r = 0; r <= 20; r++) begin
                cnt = 0;
                for (int k = 0; k < 10; k++) begin
                    offer(tlist[i], r, rdy, slot);
                    if (rdy == 0) break;
                    chk("R4 sweep slot", slot, cnt);
                    cnt++;
                end
                exp = fit_count(tlist[i], r);
                chk($sformatf("R9 count t=%0d r=%0d", tlist[i], r), cnt, exp);
                chk("R3 sweep threads", int'(free_threads), 768 - cnt * tlist[i]);
                chk("R2 sweep regs", int'(free_regs), 8192 - cnt * tlist[i] * r);
                chk("R9 sweep blocks", int'(free_blocks), 8 - cnt);
                for (int s = 0; s < cnt; s++) retire(s);
                chk("R5 sweep threads", int'(free_threads), 768);
                chk("R5 sweep regs", int'(free_regs), 8192);
                chk("R5 sweep blocks", int'(free_blocks), 8);
            end
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule